// File: doc/BRIEF.md
# Register-Mapped SPI Byte Controller

This block moves one byte at a time over a four-wire serial link. It sits on a small processor bus and exposes three byte-wide registers: control, status and data. In controller role it generates the serial clock from the system clock, drives the outgoing data line and samples the incoming one. In target role it follows a clock and select line that arrive from another device, synchronising them into its own clock domain first. Clock polarity, clock phase, bit order and the clock divider can all be set.

Software writes the control register once, then writes the data register to launch a byte. The completion flag in the status register marks the end of the exchange, and the received byte can then be read back from the data register. A write to the data register while a byte is still moving is refused and raises a collision flag. Both status flags stay set until software writes a one to them.

Top module: `spi_port`

## Requirements
- R1: After reset, control, status and data read back as 0, `sclk_o` is low and `miso_oe` is low.
- R2: Bus address 0 is the control register (read/write), address 1 is the status register (bit 7 = byte complete, bit 6 = write collision) and address 2 is the data register (a write loads the byte to send, a read returns the last byte received).
- R3: Control bits 1:0 select an SCLK period of 4, 8, 16 or 32 system clocks for codes 0 to 3. In controller role, the completion flag is set exactly 8 SCLK periods after the clock edge that accepted the data write.
- R4: Control bit 3 is clock polarity. Whenever no controller transfer is running, `sclk_o` equals this bit.
- R5: Control bit 2 is clock phase. With 0, data is sampled on the leading SCLK edge and the first output bit is already on the data line when the write is accepted, half a period before the first edge. With 1, data is sampled on the trailing edge.
- R6: Control bit 5 picks bit order: 0 sends and receives bit 7 first, 1 sends and receives bit 0 first.
- R7: Every transfer is 8 bits in each direction. The received byte appears in the data register at the same clock edge that sets the completion flag.
- R8: A data write while a byte is in progress sets the collision flag and changes neither the timing nor the content of the ongoing byte.
- R9: Writing 1 to a status bit clears that bit. Writing 0 leaves it unchanged.
- R10: With control bit 6 (enable) at 0, a data write starts nothing: SCLK does not toggle and no completion is flagged.
- R11: Control bit 4 requests controller role. When control bit 7 is 0 (select honoured) and `ss_n_i` is low, the block takes target role even if bit 4 is set: it generates no SCLK and drives `miso_oe`. When bit 7 is 1, bit 4 alone sets the role.
- R12: In target role, the block follows `sclk_i` using the same polarity, phase and order settings. It drives `miso_o` while selected, shifts in `mosi_i` and flags completion after 8 bits.
- R13: In target role with select honoured, `ss_n_i` rising mid-byte discards the partial byte, releases `miso_oe` within 3 clocks and does not set the completion flag. The next selection starts a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | DW | Bus write data |
| bus_rdata | output | DW | Bus read data (combinational) |
| sclk_o | output | 1 | Serial clock out (controller role) |
| mosi_o | output | 1 | Serial data out (controller role) |
| miso_i | input | 1 | Serial data in (controller role) |
| sclk_i | input | 1 | Serial clock in (target role) |
| ss_n_i | input | 1 | Active-low select in |
| mosi_i | input | 1 | Serial data in (target role) |
| miso_o | output | 1 | Serial data out (target role) |
| miso_oe | output | 1 | Output enable for `miso_o` |

## Verification
In controller role, the completion flag is due exactly 16 half-periods after the write-accepting edge. The bench counts falling edges from that edge and checks that the flag is still clear one cycle before and set on the cycle itself, for each divider code. Inputs from the remote device are moved at falling edges right after a shift edge, so they are stable for at least one half-period before the block samples them. In target role, every input passes through a two-flop synchroniser plus one edge register. The bench therefore holds each half-period of `sclk_i` for 8 system clocks, and it checks `miso_oe` release 3 clocks after `ss_n_i` rises, once the two-cycle synchroniser delay has passed.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW    = 8,
  parameter int PRE_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i,
  input  logic          sclk_i,
  input  logic          ss_n_i,
  input  logic          mosi_i,
  output logic          miso_o,
  output logic          miso_oe
);
  localparam int EW   = $clog2(2*DW);
  localparam int NPRE = 1 << PRE_W;
  localparam int HW   = $clog2(2 << (NPRE-1)) + 1;
  localparam logic [EW-1:0] ELAST = EW'(2*DW-1);

  logic [7:0]    ctrl;
  logic [DW-1:0] tx, rx, rx_nx, rxbuf;
  logic [EW-1:0] ecnt;
  logic [HW-1:0] hcnt, half;
  logic          busy, phase, done, wcol;
  logic [1:0]    sclk_sy, ss_sy, mosi_sy;
  logic          sclk_d;

  logic ign, en, lsb, mstr, cpol, cpha;
  assign ign  = ctrl[7];
  assign en   = ctrl[6];
  assign lsb  = ctrl[5];
  assign mstr = ctrl[4];
  assign cpol = ctrl[3];
  assign cpha = ctrl[2];
  assign half = HW'(2) << ctrl[PRE_W-1:0];

  logic sclk_s, ss_s, mosi_s;
  assign sclk_s = sclk_sy[1];
  assign ss_s   = ss_sy[1];
  assign mosi_s = mosi_sy[1];

  logic is_master, sel, slave_on, active;
  assign is_master = mstr & (ign | ss_s);
  assign sel       = ign | ~ss_s;
  assign slave_on  = en & ~is_master & sel;
  assign active    = busy | (ecnt != '0);

  logic wr_ctl, wr_stat, wr_data, load, start, collide;
  assign wr_ctl  = bus_we & (bus_addr == 2'd0);
  assign wr_stat = bus_we & (bus_addr == 2'd1);
  assign wr_data = bus_we & (bus_addr == 2'd2);
  assign load    = wr_data & en & ~active;
  assign start   = load & is_master;
  assign collide = wr_data & en & active;

  logic hend, m_edge, s_edge, ev, lead, samp, shft, last, abort_m, abort_s;
  assign hend    = ({1'b0, hcnt} == ({1'b0, half} - 1'b1));
  assign m_edge  = busy & en & is_master & hend;
  assign s_edge  = slave_on & (sclk_s != sclk_d);
  assign ev      = m_edge | s_edge;
  assign lead    = ~ecnt[0];
  assign samp    = ev & (lead ^ cpha);
  assign shft    = ev & ~(lead ^ cpha) & (cpha ? (ecnt != '0) : (ecnt != ELAST));
  assign last    = ev & (ecnt == ELAST);
  assign abort_m = busy & ~(en & is_master);
  assign abort_s = ~busy & (ecnt != '0) & ~slave_on;

  logic outbit, inbit;
  assign outbit = lsb ? tx[0] : tx[DW-1];
  assign inbit  = is_master ? miso_i : mosi_s;
  assign rx_nx  = !samp ? rx : (lsb ? {inbit, rx[DW-1:1]} : {rx[DW-2:0], inbit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0;
      ss_sy   <= '1;
      mosi_sy <= '0;
      sclk_d  <= 1'b0;
      ctrl    <= '0;
      tx      <= '0;
      rx      <= '0;
      rxbuf   <= '0;
      ecnt    <= '0;
      hcnt    <= '0;
      busy    <= 1'b0;
      phase   <= 1'b0;
      done    <= 1'b0;
      wcol    <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[0], sclk_i};
      ss_sy   <= {ss_sy[0], ss_n_i};
      mosi_sy <= {mosi_sy[0], mosi_i};
      sclk_d  <= sclk_s;
      if (wr_ctl) ctrl <= bus_wdata[7:0];
      if (load) tx <= bus_wdata;
      else if (shft) tx <= lsb ? (tx >> 1) : (tx << 1);
      rx <= rx_nx;
      if (last) rxbuf <= rx_nx;
      if (abort_m || abort_s || last) begin
        ecnt  <= '0;
        busy  <= 1'b0;
        phase <= 1'b0;
      end else begin
        if (start) begin
          busy <= 1'b1;
          hcnt <= '0;
        end else if (busy) begin
          hcnt <= hend ? '0 : hcnt + 1'b1;
        end
        if (ev) ecnt <= ecnt + 1'b1;
        if (m_edge) phase <= ~phase;
      end
      if (last) done <= 1'b1;
      else if (wr_stat && bus_wdata[7]) done <= 1'b0;
      if (collide) wcol <= 1'b1;
      else if (wr_stat && bus_wdata[6]) wcol <= 1'b0;
    end
  end

  assign sclk_o  = (en & is_master) ? (cpol ^ phase) : cpol;
  assign mosi_o  = (en & is_master) ? outbit : 1'b0;
  assign miso_o  = outbit;
  assign miso_oe = slave_on;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0:    bus_rdata[7:0] = ctrl;
      2'd1:    bus_rdata[7:6] = {done, wcol};
      2'd2:    bus_rdata = rxbuf;
      default: bus_rdata = '0;
    endcase
  end

  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o == cpol);

  a_r8_collide_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && en && is_master && wr_data && ecnt != ELAST) |=> busy);

  a_r8_collide_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && en && active) |=> wcol);

  a_r9_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !bus_wdata[7] && done) |=> done);

  a_r13_abort_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    abort_s |=> (ecnt == '0) && !$rose(done));
endmodule

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
  localparam int SH = 8;
  localparam logic [23:0] VEC [8] = '{
    {8'hD0, 8'hA5, 8'h3C}, {8'hD5, 8'h81, 8'h7E},
    {8'hDA, 8'h5A, 8'hC3}, {8'hDF, 8'h01, 8'h80},
    {8'hF0, 8'h12, 8'h34}, {8'hF6, 8'hF0, 8'h0F},
    {8'hF9, 8'h6B, 8'hD2}, {8'hFF, 8'h00, 8'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic sclk_o, mosi_o, miso_o, miso_oe;
  logic miso_i = 1'b0, sclk_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;
  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  spi_port dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .sclk_i(sclk_i), .ss_n_i(ss_n_i),
    .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe)
  );

  function automatic logic bitsel(logic [7:0] b, int i, logic l);
    return l ? b[i] : b[7-i];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic m_xfer(input logic [7:0] ctl, tx, sl, input int coll, output logic [7:0] cap);
    int h, be, mi, ck;
    logic pol, pha, l, prev;
    logic [7:0] r;
    h = 2 << ctl[1:0]; pha = ctl[2]; pol = ctl[3]; l = ctl[5];
    wr(2'd0, ctl);
    rd(2'd0, r);
    check(r == ctl, "R2 control readback", r, ctl);
    check(sclk_o == pol, "R4 idle level", sclk_o, pol);
    be = 0; mi = 0; ck = 0; prev = pol; cap = 8'h00;
    miso_i = bitsel(sl, 0, l);
    wr(2'd2, tx);
    if (!pha) check(mosi_o == bitsel(tx, 0, l) && sclk_o == pol,
                    "R5 first bit early", mosi_o, bitsel(tx, 0, l));
    bus_addr = 2'd1;
    for (int c = 1; c <= 16*h; c++) begin
      @(negedge clk);
      if (c == coll) begin
        bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'hFF;
      end else if (c == coll + 1) begin
        bus_we = 1'b0; bus_addr = 2'd1;
      end
      if (sclk_o !== prev) begin
        if (((be % 2) == 0) ^ pha) begin
          if (ck < 8) cap[l ? ck : 7-ck] = mosi_o;
          ck++;
        end else if (pha ? (be != 0) : (be != 15)) begin
          mi++;
          if (mi < 8) miso_i = bitsel(sl, mi, l);
        end
        be++;
      end
      prev = sclk_o;
      if (c == 16*h-1) begin
        #1 check(bus_rdata[7] == 1'b0, "R3 done not early", bus_rdata[7], 0);
      end
      if (c == 16*h) begin
        #1 check(bus_rdata[7] == 1'b1, "R3 done on time", bus_rdata[7], 1);
      end
    end
    check(sclk_o == pol, "R4 idle after byte", sclk_o, pol);
    rd(2'd2, r);
    check(r == sl, "R7 received byte", r, sl);
  endtask

  task automatic sl_xfer(input logic [7:0] mb, input int nb, input logic pol, pha, l,
                         output logic [7:0] got);
    int j, k;
    got = 8'h00; k = 0;
    j = pha ? 0 : 1;
    sclk_i = pol;
    if (!pha) mosi_i = bitsel(mb, 0, l);
    ss_n_i = 1'b0;
    for (int e = 0; e < 2*nb; e++) begin
      repeat (SH) @(negedge clk);
      sclk_i = ~sclk_i;
      if (((e % 2) == 0) ^ pha) begin
        if (k < 8) got[l ? k : 7-k] = miso_o;
        k++;
      end else begin
        if (j < 8) mosi_i = bitsel(mb, j, l);
        j++;
      end
    end
    repeat (SH) @(negedge clk);
    ss_n_i = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic [7:0] r, cap;
    int tg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, r); check(r == 8'h00, "R1 control reset", r, 0);
    rd(2'd1, r); check(r == 8'h00, "R1 status reset", r, 0);
    rd(2'd2, r); check(r == 8'h00, "R1 data reset", r, 0);
    check(sclk_o == 1'b0 && miso_oe == 1'b0, "R1 pins reset", {sclk_o, miso_oe}, 0);

    for (int v = 0; v < 8; v++) begin
      m_xfer(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], -10, cap);
      check(cap == VEC[v][15:8], "R5 R6 sent byte order and phase", cap, VEC[v][15:8]);
      wr(2'd1, 8'hC0);
    end

    m_xfer(8'hD1, 8'h3C, 8'h99, 20, cap);
    check(cap == 8'h3C, "R8 shift untouched", cap, 8'h3C);
    rd(2'd1, r); check(r == 8'hC0, "R8 collision flag", r, 8'hC0);

    wr(2'd1, 8'h00); rd(2'd1, r); check(r == 8'hC0, "R9 zero write keeps", r, 8'hC0);
    wr(2'd1, 8'h80); rd(2'd1, r); check(r == 8'h40, "R9 clear done only", r, 8'h40);
    wr(2'd1, 8'h40); rd(2'd1, r); check(r == 8'h00, "R9 clear collision", r, 0);

    wr(2'd0, 8'h90);
    wr(2'd2, 8'h55);
    tg = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (sclk_o !== 1'b0) tg++;
    end
    check(tg == 0, "R10 no clock when disabled", tg, 0);
    rd(2'd1, r); check(r == 8'h00, "R10 no completion", r, 0);

    ss_n_i = 1'b0;
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h50);
    wr(2'd2, 8'h77);
    tg = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (sclk_o !== 1'b0) tg++;
    end
    check(tg == 0 && miso_oe == 1'b1, "R11 select forces target role", {tg[7:0], miso_oe}, 1);
    check(miso_o == 1'b0, "R11 first target bit ready", miso_o, 0);
    sl_xfer(8'hA6, 8, 1'b0, 1'b0, 1'b0, cap);
    check(cap == 8'h77, "R12 target sent", cap, 8'h77);
    rd(2'd2, r); check(r == 8'hA6, "R12 target received", r, 8'hA6);
    rd(2'd1, r); check(r == 8'h80, "R12 target done", r, 8'h80);

    sclk_i = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h6C);
    wr(2'd1, 8'hC0);
    wr(2'd2, 8'h4D);
    sl_xfer(8'hB2, 8, 1'b1, 1'b1, 1'b1, cap);
    check(cap == 8'h4D, "R12 target lsb cpha1 sent", cap, 8'h4D);
    rd(2'd2, r); check(r == 8'hB2, "R12 target lsb cpha1 received", r, 8'hB2);

    sclk_i = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd0, 8'h40);
    wr(2'd1, 8'hC0);
    wr(2'd2, 8'hE1);
    sl_xfer(8'h5F, 3, 1'b0, 1'b0, 1'b0, cap);
    repeat (3) @(negedge clk);
    check(miso_oe == 1'b0, "R13 output released", miso_oe, 0);
    rd(2'd1, r); check(r == 8'h00, "R13 no completion on abort", r, 0);
    wr(2'd2, 8'h2B);
    sl_xfer(8'h90, 8, 1'b0, 1'b0, 1'b0, cap);
    check(cap == 8'h2B, "R13 fresh byte sent", cap, 8'h2B);
    rd(2'd2, r); check(r == 8'h90, "R13 fresh byte received", r, 8'h90);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule